// File: doc/BRIEF.md
# Free-fall and motion interrupt detector

This block watches a stream of three-axis acceleration samples and drives one combined interrupt pin plus two status flags. Every accepted sample is reduced to an 8-bit magnitude per axis. A debounce decimator then picks which of the accepted samples actually count. Two independent debounced detectors run on those chosen samples. The free-fall detector needs every axis to be quiet. The motion detector needs any one axis to be loud.

Each detector has its own threshold, its own run-length delay and its own latch option. A latched free-fall event is released through its enable bit. A latched motion event is released through the motion-enable pin. Software may also clear either flag with a status write. The pin ORs the free-fall flag with the motion flag, and the motion flag only reaches the pin while motion-enable is high. The block sits behind a converter that delivers signed samples with a valid strobe. The host controls it through static configuration inputs.

Top module: `fall_motion_irq`

## Requirements
- R1: After reset, irq_pin, ff_flag and mot_flag are all 0.
- R2: For each axis, the magnitude byte is bits 10:3 of |sample|, with the sample signed 12-bit and |sample| saturated at 2047. A debounce sample qualifies for free-fall when the magnitude byte of all three axes is strictly below ff_thr.
- R3: A debounce sample qualifies for motion when the magnitude byte of at least one axis is strictly above mot_thr.
- R4: A detector meets its criterion on the debounce sample that makes the number of consecutive qualifying samples greater than its delay. A delay of 0 meets on the first qualifying sample, and a delay of 255 meets on the 256th. The run length saturates and does not wrap. A non-qualifying debounce sample resets the run to zero.
- R5: A sample is accepted when smp_vld and ce are both high. cfg_rate = r makes every 2^r-th accepted sample a debounce sample, so r = 0, 1, 2 and 3 give 1, 2, 4 and 8. After reset the first accepted sample is a debounce sample. Accepted samples that are not chosen have no effect.
- R6: When its latch bit is 0, a flag takes, on each debounce sample, the value "criterion met" and holds it until the next debounce sample. The flags change on the clock edge that accepts the sample.
- R7: When cfg_ff_lat is 1, ff_flag stays 1 once the free-fall criterion is met. While cfg_ff_en is 0, ff_flag is 0 on the next edge, and no free-fall flag is produced.
- R8: When cfg_mot_lat is 1, mot_flag stays 1 once the motion criterion is met. It is cleared on the edge after mot_en is sampled low.
- R9: irq_pin equals ff_flag OR (mot_flag AND mot_en), combinationally from the current mot_en.
- R10: When stat_we is 1, stat_wd[0] = 0 clears ff_flag and stat_wd[1] = 0 clears mot_flag on that edge, and a clear wins over a set. A bit written as 1 leaves its flag unchanged. This works whatever the state of ce.
- R11: With ce = 0, smp_vld and the sample inputs have no effect on the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce | input | 1 | Clock-enable tick qualifying the sample strobe |
| smp_vld | input | 1 | Sample valid strobe |
| smp_x | input | 12 | Signed X-axis sample |
| smp_y | input | 12 | Signed Y-axis sample |
| smp_z | input | 12 | Signed Z-axis sample |
| ff_thr | input | 8 | Free-fall threshold on the magnitude byte |
| ff_dly | input | 8 | Free-fall debounce delay |
| mot_thr | input | 8 | Motion threshold on the magnitude byte |
| mot_dly | input | 8 | Motion debounce delay |
| cfg_ff_en | input | 1 | Free-fall enable; low clears and blocks the free-fall flag |
| cfg_ff_lat | input | 1 | Free-fall latch select |
| cfg_mot_lat | input | 1 | Motion latch select |
| cfg_rate | input | 2 | Debounce decimation select |
| mot_en | input | 1 | Motion enable pin; gates motion onto irq_pin and clears the motion latch |
| stat_we | input | 1 | Status write strobe |
| stat_wd | input | 2 | Status write data; bit 0 free-fall, bit 1 motion, 0 clears |
| irq_pin | output | 1 | Combined interrupt output |
| ff_flag | output | 1 | Free-fall interrupt status |
| mot_flag | output | 1 | Motion interrupt status |

## Verification
The bench builds the block with its default parameters: 12-bit samples, 8-bit thresholds and delays, and a 2-bit rate field. This puts the full 255-sample delay and the 8-way decimator within reach in a short run. Directed runs hit the saturating run counter at 255 and 256 qualifying samples, the decimator phase after reset, and the three clear mechanisms racing against a set. A randomised phase then toggles latch modes, enables and status writes against a behavioural model, with the two detectors running at once.

// File: rtl/fmd_pkg.sv
package fmd_pkg;
  localparam int unsigned FMD_AXES = 3;

  typedef enum logic {
    DET_ALL_BELOW = 1'b0,
    DET_ANY_ABOVE = 1'b1
  } det_kind_e;
endpackage

// File: rtl/fmd_axis_mag.sv
module fmd_axis_mag #(
  parameter int unsigned SMP_W = 12,
  parameter int unsigned THR_W = 8
) (
  input  logic signed [SMP_W-1:0] smp,
  output logic        [THR_W-1:0] mag_hi
);
  localparam int unsigned MAG_W = SMP_W - 1;

  logic             neg;
  logic [SMP_W-1:0] inv;
  logic [MAG_W-1:0] mag;

  always_comb begin
    neg = smp[SMP_W-1];
    inv = (~smp) + {{(SMP_W-1){1'b0}}, 1'b1};
    if (!neg) begin
      mag = smp[MAG_W-1:0];
    end else if (inv[SMP_W-1]) begin
      mag = {MAG_W{1'b1}};
    end else begin
      mag = inv[MAG_W-1:0];
    end
    mag_hi = mag[MAG_W-1 -: THR_W];
  end
endmodule

// File: rtl/fmd_decim.sv
module fmd_decim #(
  parameter int unsigned RATE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc,
  input  logic [RATE_W-1:0] rate,
  output logic              take
);
  localparam int unsigned CNT_W = (1 << RATE_W) - 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W:0]   div;
  logic [CNT_W:0]   inc;

  always_comb begin
    div   = {{CNT_W{1'b0}}, 1'b1} << rate;
    inc   = {1'b0, cnt_q} + {{CNT_W{1'b0}}, 1'b1};
    cnt_d = cnt_q;
    if (acc) begin
      if (inc >= div) begin
        cnt_d = '0;
      end else begin
        cnt_d = inc[CNT_W-1:0];
      end
    end
    take = acc && (cnt_q == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (acc) begin
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/fmd_debounce.sv
module fmd_debounce
  import fmd_pkg::*;
#(
  parameter int unsigned N_AX  = FMD_AXES,
  parameter int unsigned THR_W = 8,
  parameter int unsigned DLY_W = 8,
  parameter det_kind_e   KIND  = DET_ALL_BELOW
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       take,
  input  logic [N_AX-1:0][THR_W-1:0] mag,
  input  logic [THR_W-1:0]           thr,
  input  logic [DLY_W-1:0]           dly,
  input  logic                       en,
  input  logic                       lat,
  input  logic                       clr,
  output logic                       flag
);
  logic [N_AX-1:0]  ax_hit;
  logic             crit;
  logic             hit;
  logic [DLY_W-1:0] run_q;
  logic [DLY_W-1:0] run_d;
  logic [DLY_W:0]   run_inc;
  logic             flag_q;
  logic             flag_d;

  genvar g;
  generate
    for (g = 0; g < N_AX; g++) begin : g_ax
      if (KIND == DET_ALL_BELOW) begin : g_lo
        assign ax_hit[g] = mag[g] < thr;
      end else begin : g_hi
        assign ax_hit[g] = mag[g] > thr;
      end
    end
    if (KIND == DET_ALL_BELOW) begin : g_all
      assign crit = &ax_hit;
    end else begin : g_any
      assign crit = |ax_hit;
    end
  endgenerate

  always_comb begin
    run_inc = {1'b0, run_q} + {{DLY_W{1'b0}}, 1'b1};
    hit     = crit && (run_inc > {1'b0, dly});
    run_d   = run_q;
    if (take) begin
      if (!crit) begin
        run_d = '0;
      end else if (run_q != {DLY_W{1'b1}}) begin
        run_d = run_inc[DLY_W-1:0];
      end
    end
  end

  always_comb begin
    flag_d = flag_q;
    if (!en || clr) begin
      flag_d = 1'b0;
    end else if (take) begin
      if (lat) begin
        flag_d = flag_q | hit;
      end else begin
        flag_d = hit;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
    end else if (take) begin
      run_q <= run_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else begin
      flag_q <= flag_d;
    end
  end

  assign flag = flag_q;
endmodule

// File: rtl/fall_motion_irq.sv
module fall_motion_irq
  import fmd_pkg::*;
#(
  parameter int unsigned SMP_W  = 12,
  parameter int unsigned THR_W  = 8,
  parameter int unsigned DLY_W  = 8,
  parameter int unsigned RATE_W = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ce,
  input  logic                    smp_vld,
  input  logic signed [SMP_W-1:0] smp_x,
  input  logic signed [SMP_W-1:0] smp_y,
  input  logic signed [SMP_W-1:0] smp_z,
  input  logic [THR_W-1:0]        ff_thr,
  input  logic [DLY_W-1:0]        ff_dly,
  input  logic [THR_W-1:0]        mot_thr,
  input  logic [DLY_W-1:0]        mot_dly,
  input  logic                    cfg_ff_en,
  input  logic                    cfg_ff_lat,
  input  logic                    cfg_mot_lat,
  input  logic [RATE_W-1:0]       cfg_rate,
  input  logic                    mot_en,
  input  logic                    stat_we,
  input  logic [1:0]              stat_wd,
  output logic                    irq_pin,
  output logic                    ff_flag,
  output logic                    mot_flag
);
  localparam int unsigned N_AX = FMD_AXES;

  logic signed [SMP_W-1:0]    smp_arr [N_AX];
  logic [N_AX-1:0][THR_W-1:0] mag;
  logic                       acc;
  logic                       take;
  logic                       ff_clr;
  logic                       mot_clr;

  assign smp_arr[0] = smp_x;
  assign smp_arr[1] = smp_y;
  assign smp_arr[2] = smp_z;

  genvar g;
  generate
    for (g = 0; g < N_AX; g++) begin : g_mag
      fmd_axis_mag #(
        .SMP_W (SMP_W),
        .THR_W (THR_W)
      ) u_mag (
        .smp    (smp_arr[g]),
        .mag_hi (mag[g])
      );
    end
  endgenerate

  assign acc = ce && smp_vld;

  fmd_decim #(
    .RATE_W (RATE_W)
  ) u_decim (
    .clk   (clk),
    .rst_n (rst_n),
    .acc   (acc),
    .rate  (cfg_rate),
    .take  (take)
  );

  assign ff_clr  = stat_we && !stat_wd[0];
  assign mot_clr = (stat_we && !stat_wd[1]) || (cfg_mot_lat && !mot_en);

  fmd_debounce #(
    .N_AX  (N_AX),
    .THR_W (THR_W),
    .DLY_W (DLY_W),
    .KIND  (DET_ALL_BELOW)
  ) u_ff (
    .clk   (clk),
    .rst_n (rst_n),
    .take  (take),
    .mag   (mag),
    .thr   (ff_thr),
    .dly   (ff_dly),
    .en    (cfg_ff_en),
    .lat   (cfg_ff_lat),
    .clr   (ff_clr),
    .flag  (ff_flag)
  );

  fmd_debounce #(
    .N_AX  (N_AX),
    .THR_W (THR_W),
    .DLY_W (DLY_W),
    .KIND  (DET_ANY_ABOVE)
  ) u_mot (
    .clk   (clk),
    .rst_n (rst_n),
    .take  (take),
    .mag   (mag),
    .thr   (mot_thr),
    .dly   (mot_dly),
    .en    (1'b1),
    .lat   (cfg_mot_lat),
    .clr   (mot_clr),
    .flag  (mot_flag)
  );

  assign irq_pin = ff_flag || (mot_flag && mot_en);
endmodule

// File: rtl/fmd_chk.sv
module fmd_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ce,
  input logic       smp_vld,
  input logic       cfg_ff_en,
  input logic       cfg_mot_lat,
  input logic       mot_en,
  input logic       stat_we,
  input logic [1:0] stat_wd,
  input logic       irq_pin,
  input logic       ff_flag,
  input logic       mot_flag
);
  AST_FF_EN_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_ff_en |=> !ff_flag); // R7
  AST_MOT_LATCH_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mot_lat && !mot_en) |=> !mot_flag); // R8
  AST_STAT_CLR_FF: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_we && !stat_wd[0]) |=> !ff_flag); // R10
  AST_STAT_CLR_MOT: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_we && !stat_wd[1]) |=> !mot_flag); // R10
  AST_NO_RISE_FF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(ce && smp_vld) |=> !$rose(ff_flag)); // R11
  AST_NO_RISE_MOT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(ce && smp_vld) |=> !$rose(mot_flag)); // R11
  AST_PIN_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pin |-> (ff_flag || mot_en)); // R9
endmodule

bind fall_motion_irq fmd_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ce          (ce),
  .smp_vld     (smp_vld),
  .cfg_ff_en   (cfg_ff_en),
  .cfg_mot_lat (cfg_mot_lat),
  .mot_en      (mot_en),
  .stat_we     (stat_we),
  .stat_wd     (stat_wd),
  .irq_pin     (irq_pin),
  .ff_flag     (ff_flag),
  .mot_flag    (mot_flag)
);

// File: tb/fall_motion_irq_tb.sv
module fall_motion_irq_tb;
  logic              clk = 1'b0;
  logic              rst_n;
  logic              ce;
  logic              smp_vld;
  logic signed [11:0] sx, sy, sz;
  logic [7:0]        ff_thr, ff_dly, mot_thr, mot_dly;
  logic              ff_en, ff_lat, mot_lat, mot_en, stat_we;
  logic [1:0]        rate, stat_wd;
  logic              irq_pin, ff_flag, mot_flag;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  int dc, ffr, mor;
  bit mff, mmot;

  always #5 clk = ~clk;

  fall_motion_irq u_dut (
    .clk (clk), .rst_n (rst_n), .ce (ce), .smp_vld (smp_vld),
    .smp_x (sx), .smp_y (sy), .smp_z (sz),
    .ff_thr (ff_thr), .ff_dly (ff_dly), .mot_thr (mot_thr), .mot_dly (mot_dly),
    .cfg_ff_en (ff_en), .cfg_ff_lat (ff_lat), .cfg_mot_lat (mot_lat),
    .cfg_rate (rate), .mot_en (mot_en), .stat_we (stat_we), .stat_wd (stat_wd),
    .irq_pin (irq_pin), .ff_flag (ff_flag), .mot_flag (mot_flag)
  );

  function automatic int magb(input logic signed [11:0] v);
    int a;
    a = int'(v);
    if (a < 0) a = -a;
    if (a > 2047) a = 2047;
    return a / 8;
  endfunction

  // behavioural reference model
  always @(posedge clk or negedge rst_n) begin : model
    bit acc, take, allb, anya, hf, hm;
    int mx, my, mz;
    if (!rst_n) begin
      dc = 0; ffr = 0; mor = 0; mff = 0; mmot = 0;
    end else begin
      acc  = ce && smp_vld;
      take = acc && (dc == 0);
      if (acc) begin
        dc = dc + 1;
        if (dc >= (1 << rate)) dc = 0;
      end
      mx = magb(sx); my = magb(sy); mz = magb(sz);
      allb = (mx < ff_thr) && (my < ff_thr) && (mz < ff_thr);
      anya = (mx > mot_thr) || (my > mot_thr) || (mz > mot_thr);
      if (take) begin
        ffr = allb ? ((ffr < 256) ? ffr + 1 : 256) : 0;
        mor = anya ? ((mor < 256) ? mor + 1 : 256) : 0;
      end
      hf = take && allb && (ffr > ff_dly);
      hm = take && anya && (mor > mot_dly);
      if (!ff_en || (stat_we && !stat_wd[0])) mff = 0;
      else if (take) mff = ff_lat ? (mff | hf) : hf;
      if ((mot_lat && !mot_en) || (stat_we && !stat_wd[1])) mmot = 0;
      else if (take) mmot = mot_lat ? (mmot | hm) : hm;
    end
  end

  task automatic chk(input bit got, input bit exp, input string tag);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%0b exp=%0b t=%0t", tag, got, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison against the model
  always begin
    @(negedge clk);
    #2;
    if (rst_n && !done) begin
      chk(ff_flag, mff, "R6 ff_flag vs model");
      chk(mot_flag, mmot, "R6 mot_flag vs model");
      chk(irq_pin, mff | (mmot & mot_en), "R9 irq_pin vs model");
    end
  end

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
  endtask

  task automatic send(input int x, input int y, input int z);
    @(negedge clk);
    sx = 12'(x); sy = 12'(y); sz = 12'(z); smp_vld = 1;
    @(negedge clk);
    smp_vld = 0;
    #3;
  endtask

  task automatic swr(input logic [1:0] d);
    @(negedge clk); stat_we = 1; stat_wd = d;
    @(negedge clk); stat_we = 0;
    #3;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : stim
    rst_n = 0; ce = 1; smp_vld = 0; sx = 0; sy = 0; sz = 0;
    ff_thr = 8; mot_thr = 100; ff_dly = 2; mot_dly = 0;
    ff_en = 1; ff_lat = 0; mot_lat = 0; mot_en = 1; rate = 0;
    stat_we = 0; stat_wd = 2'b11;
    repeat (3) @(negedge clk);
    #3;
    chk(ff_flag, 0, "R1 reset ff_flag");
    chk(mot_flag, 0, "R1 reset mot_flag");
    chk(irq_pin, 0, "R1 reset irq_pin");
    rst_n = 1;

    // free-fall, unlatched, delay 2
    send(-10, 20, 5);  chk(ff_flag, 0, "R4 ff run 1 of 3");
    send(30, -40, 0);  chk(ff_flag, 0, "R4 ff run 2 of 3");
    send(0, 0, -63);   chk(ff_flag, 1, "R2 ff met on run 3");
    chk(irq_pin, 1, "R9 pin from ff");
    send(0, 500, 0);   chk(ff_flag, 0, "R6 ff drops when one axis high");

    // motion, unlatched, delay 0
    send(0, -1000, 0); chk(mot_flag, 1, "R3 motion on one axis");
    chk(irq_pin, 1, "R9 pin from motion");
    @(negedge clk); mot_en = 0; #3;
    chk(irq_pin, 0, "R9 pin gated by mot_en");
    chk(mot_flag, 1, "R9 unlatched flag kept with mot_en low");
    mot_en = 1;
    send(0, 0, 800);   chk(mot_flag, 0, "R3 byte 100 not above 100");

    // motion latched
    mot_lat = 1;
    send(1500, 0, 0);  chk(mot_flag, 1, "R8 latched motion set");
    send(0, 0, 0);     chk(mot_flag, 1, "R8 latched motion held");
    @(negedge clk); mot_en = 0;
    @(negedge clk); #3;
    chk(mot_flag, 0, "R8 mot_en low clears latch");
    mot_en = 1; mot_lat = 0;

    // free-fall latched
    ff_lat = 1; ff_dly = 0;
    send(1, 1, 1);     chk(ff_flag, 1, "R4 delay 0 meets on first");
    send(2000, 0, 0);  chk(ff_flag, 1, "R7 latched ff held");
    swr(2'b01);        chk(ff_flag, 1, "R10 write 1 leaves ff");
    swr(2'b10);        chk(ff_flag, 0, "R10 write 0 clears ff");
    send(1, 1, 1);     chk(ff_flag, 1, "R7 latched ff set again");
    @(negedge clk); ff_en = 0;
    @(negedge clk); #3;
    chk(ff_flag, 0, "R7 ff_en low clears");
    send(1, 1, 1);     chk(ff_flag, 0, "R7 no ff while disabled");
    ff_en = 1; ff_lat = 0;

    // clock enable low
    send(2000, 0, 0);  chk(ff_flag, 0, "R11 setup");
    ce = 0;
    send(1, 1, 1); send(1, 1, 1);
    chk(ff_flag, 0, "R11 samples ignored with ce low");
    ce = 1;

    // decimation by 4
    do_reset();
    rate = 2; ff_dly = 1;
    send(1, 1, 1);     chk(ff_flag, 0, "R5 first taken, run 1");
    send(2000, 0, 0); send(2000, 0, 0); send(2000, 0, 0);
    chk(ff_flag, 0, "R5 skipped samples");
    send(1, 1, 1);     chk(ff_flag, 1, "R5 fifth accepted is taken");
    rate = 0;

    // saturation at delay 255
    do_reset();
    ff_dly = 255;
    for (int i = 0; i < 255; i++) send(0, 0, 0);
    chk(ff_flag, 0, "R4 255 samples not enough");
    send(0, 0, 0);     chk(ff_flag, 1, "R4 256th sample meets");
    send(0, 0, 0);     chk(ff_flag, 1, "R4 run saturates");

    // randomised phase
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      ce      = ($urandom % 8) != 0;
      smp_vld = ($urandom % 3) != 0;
      if (($urandom % 2) == 0) begin
        sx = 12'($urandom % 80) - 12'sd40; sy = 12'($urandom % 80) - 12'sd40;
        sz = 12'($urandom % 80) - 12'sd40;
      end else begin
        sx = 12'($urandom); sy = 12'($urandom); sz = 12'($urandom);
      end
      stat_we = ($urandom % 16) == 0;
      stat_wd = 2'($urandom);
      if (($urandom % 32) == 0) begin
        ff_en = $urandom; ff_lat = $urandom; mot_lat = $urandom;
        rate = 2'($urandom); ff_dly = 8'($urandom % 4); mot_dly = 8'($urandom % 4);
        ff_thr = 8'($urandom % 16); mot_thr = 8'(60 + $urandom % 120);
      end
      if (($urandom % 12) == 0) mot_en = ~mot_en;
    end
    @(negedge clk); smp_vld = 0; stat_we = 0;
    repeat (3) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule